// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through eight 16-bit registers. Two setup registers hold the configuration: shift enable, clock divisor, completion interrupt enables, the SCLK edge on which MISO is sampled, and the polarity and style (level or pulse) of the interrupt. Software places outgoing data in two 16-bit transmit halves. It then writes the control register to start either a write shift or a read shift. Each command carries its own word length, from 1 to 32 bits.

A write shifts out the top bits of the 32-bit transmit word, MSB first. A read holds MOSI low and collects MISO bits into two 16-bit receive halves, right-aligned. Each command type has its own done flag in the status register, and each flag can raise the interrupt output. A separate control-register form drives one of two active-low chip selects, or releases both, without starting a shift.

Top module: `spi_regmaster`

## Requirements
- R1: After reset all registers read 0, both chip selects are high, SCLK sits high (the falling-edge idle level) and the interrupt output is high.
- R2: A control write with bit 1 set starts a write of n bits, where bits 6:2 of the control word hold n-1. The n bits are taken MSB first from the top of the 32-bit word formed with transmit-high (index 5) above transmit-low (index 4). An 8-bit word therefore goes in the upper byte of transmit-high.
- R3: A control write with bit 0 set (and bit 1 clear) starts a read of n bits. MOSI stays low for the whole read. When the read completes, the n received bits appear right-aligned in receive-low (index 6, bits 15:0) and receive-high (index 7, bits 31:16).
- R4: Status register (index 3): bit 0 is read-done, bit 1 is write-done and bit 2 is busy. An accepted command clears its own done flag. A write to the status register keeps only the flags whose written bit is 1.
- R5: While setup1 bit 0 is 0, shift commands are ignored: busy stays 0, no flag sets and SCLK does not toggle.
- R6: A shift command that arrives while a shift is in progress is ignored completely.
- R7: The divisor in setup1 bits 3:1 holds each SCLK phase for 2^d clock cycles, so one bit lasts 2^(d+1) cycles.
- R8: Setup2 bit 0 selects the sampling edge. With 0, SCLK idles high and MISO is sampled on the falling edge. With 1, SCLK idles low and MISO is sampled on the rising edge. MOSI changes only on the edge that returns SCLK to idle.
- R9: A control write with bit 10 set is a chip-select command. With bit 0 clear it drives cs_n[bit 7] low and the other chip select high. With bit 0 set it drives both chip selects high. It starts no shift.
- R10: Setup1 bit 4 enables the write-done interrupt and bit 5 enables the read-done interrupt. Setup2 bit 5 sets the polarity (1 = active high). When setup2 bit 10 is 0 (level), the interrupt stays active while an enabled flag is set. When bit 10 is 1 (pulse), the interrupt is active for exactly one cycle per enabled completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 3 | Register index (byte offset divided by two) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
A corrupted bit counter or transmit shift register shows up on MOSI within the same frame. The result is a captured word with wrong content or length, or extra SCLK edges after the done flag. Those edges are caught before the next command starts. Errors in the receive path or in flag handling reach the ports on the next register read or on the interrupt pin within one or two cycles of completion. A divider that runs at the wrong rate changes the measured spacing of sampling edges inside the first frame that uses it.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int REG_W = 16;

  typedef enum logic [2:0] {
    IDX_SETUP1 = 3'd0,
    IDX_SETUP2 = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_STATUS = 3'd3,
    IDX_TXLO   = 3'd4,
    IDX_TXHI   = 3'd5,
    IDX_RXLO   = 3'd6,
    IDX_RXHI   = 3'd7
  } reg_idx_e;

  // setup1 fields
  localparam int S1_RUN     = 0;
  localparam int S1_DIV_LSB = 1;
  localparam int S1_IE_WR   = 4;
  localparam int S1_IE_RD   = 5;
  // setup2 fields
  localparam int S2_RISE    = 0;
  localparam int S2_POL     = 5;
  localparam int S2_PULSE   = 10;
  // control fields
  localparam int C_RD       = 0;
  localparam int C_WR       = 1;
  localparam int C_LEN_LSB  = 2;
  localparam int C_CS_SEL   = 7;
  localparam int C_CS_CMD   = 10;
  // status fields
  localparam int ST_RD      = 0;
  localparam int ST_WR      = 1;
  localparam int ST_BUSY    = 2;
endpackage

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = ((1 << DIV_W) - 1 > 0) ? (1 << DIV_W) - 1 : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = ~({CNT_W{1'b1}} << div);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_wr,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              phase,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              done_wr,
  output logic              done_rd
);
  localparam int BW = LEN_W + 1;
  localparam logic [BW-1:0] ONE = BW'(1);

  logic              busy_q, phase_q, wr_q;
  logic [BW-1:0]     bits_q;
  logic [WORD_W-1:0] txsr_q, rxsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      wr_q    <= 1'b0;
      bits_q  <= '0;
      txsr_q  <= '0;
      rxsr_q  <= '0;
      done_wr <= 1'b0;
      done_rd <= 1'b0;
    end else begin
      done_wr <= 1'b0;
      done_rd <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        wr_q    <= is_wr;
        bits_q  <= {1'b0, len_m1} + ONE;
        txsr_q  <= is_wr ? tx_word : '0;
        rxsr_q  <= '0;
      end else if (busy_q && tick) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          rxsr_q  <= {rxsr_q[WORD_W-2:0], miso};
        end else begin
          phase_q <= 1'b0;
          txsr_q  <= txsr_q << 1;
          bits_q  <= bits_q - ONE;
          if (bits_q == ONE) begin
            busy_q  <= 1'b0;
            done_wr <= wr_q;
            done_rd <= !wr_q;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign phase   = phase_q;
  assign mosi    = txsr_q[WORD_W-1];
  assign rx_word = rxsr_q;

  assert_idle_phase_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !phase_q);
  assert_read_mosi_low_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !wr_q) |-> !txsr_q[WORD_W-1]);
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> ($stable(txsr_q) && $stable(bits_q)));
  assert_bits_live_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> bits_q != '0);
endmodule

// File: rtl/spi_rm_irq.sv
module spi_rm_irq (
  input  logic clk,
  input  logic rst,
  input  logic pulse_mode,
  input  logic act_high,
  input  logic en_wr,
  input  logic en_rd,
  input  logic flag_wr,
  input  logic flag_rd,
  input  logic done_wr,
  input  logic done_rd,
  output logic irq
);
  logic act_w, act_q, irq_q;

  always_comb begin
    if (pulse_mode) act_w = (done_wr && en_wr) || (done_rd && en_rd);
    else            act_w = (flag_wr && en_wr) || (flag_rd && en_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      irq_q <= 1'b1;
    end else begin
      act_q <= act_w;
      irq_q <= act_high ? act_w : !act_w;
    end
  end

  assign irq = irq_q;

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && act_q) |=> (!act_q || !pulse_mode));
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              irq
);
  localparam int WORD_W = 2 * REG_W;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [REG_W-1:0]  setup1_q, setup2_q, ctrl_q, txlo_q, txhi_q, rxlo_q, rxhi_q;
  logic [REG_W-1:0]  rdata_q, status_w;
  logic              flag_wr_q, flag_rd_q;
  logic [NUM_CS-1:0] cs_n_q;
  logic              busy, phase, done_wr, done_rd, tick, mosi_w, irq_w;
  logic [WORD_W-1:0] rx_word;
  logic              ctrl_wr, stat_wr, cs_cmd, start_req, accept, cmd_wr;
  logic [SEL_W-1:0]  cs_sel;
  reg_idx_e          idx;

  assign idx       = reg_idx_e'(reg_addr);
  assign ctrl_wr   = reg_wr && (idx == IDX_CTRL);
  assign stat_wr   = reg_wr && (idx == IDX_STATUS);
  assign cs_cmd    = reg_wdata[C_CS_CMD];
  assign cmd_wr    = reg_wdata[C_WR];
  assign cs_sel    = reg_wdata[C_CS_SEL +: SEL_W];
  assign start_req = ctrl_wr && !cs_cmd && (reg_wdata[C_WR] || reg_wdata[C_RD]);
  assign accept    = start_req && setup1_q[S1_RUN] && !busy;

  // configuration, data and receive registers
  always_ff @(posedge clk) begin
    if (rst) begin
      setup1_q <= '0; setup2_q <= '0; ctrl_q <= '0;
      txlo_q   <= '0; txhi_q   <= '0;
      rxlo_q   <= '0; rxhi_q   <= '0;
    end else begin
      if (reg_wr) begin
        case (idx)
          IDX_SETUP1: setup1_q <= reg_wdata;
          IDX_SETUP2: setup2_q <= reg_wdata;
          IDX_CTRL:   ctrl_q   <= reg_wdata;
          IDX_TXLO:   txlo_q   <= reg_wdata;
          IDX_TXHI:   txhi_q   <= reg_wdata;
          default: ;
        endcase
      end
      if (done_rd) {rxhi_q, rxlo_q} <= rx_word;
    end
  end

  // completion flags
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_wr_q <= 1'b0;
      flag_rd_q <= 1'b0;
    end else begin
      if (accept && cmd_wr)  flag_wr_q <= 1'b0;
      else if (done_wr)      flag_wr_q <= 1'b1;
      else if (stat_wr)      flag_wr_q <= flag_wr_q && reg_wdata[ST_WR];

      if (accept && !cmd_wr) flag_rd_q <= 1'b0;
      else if (done_rd)      flag_rd_q <= 1'b1;
      else if (stat_wr)      flag_rd_q <= flag_rd_q && reg_wdata[ST_RD];
    end
  end

  // chip selects
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= '1;
    end else if (ctrl_wr && cs_cmd) begin
      for (int i = 0; i < NUM_CS; i++)
        cs_n_q[i] <= reg_wdata[C_RD] || (cs_sel != SEL_W'(i));
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[ST_RD]   = flag_rd_q;
    status_w[ST_WR]   = flag_wr_q;
    status_w[ST_BUSY] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (idx)
        IDX_SETUP1: rdata_q <= setup1_q;
        IDX_SETUP2: rdata_q <= setup2_q;
        IDX_CTRL:   rdata_q <= ctrl_q;
        IDX_STATUS: rdata_q <= status_w;
        IDX_TXLO:   rdata_q <= txlo_q;
        IDX_TXHI:   rdata_q <= txhi_q;
        IDX_RXLO:   rdata_q <= rxlo_q;
        default:    rdata_q <= rxhi_q;
      endcase
    end
  end

  spi_rm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (setup1_q[S1_DIV_LSB +: DIV_W]),
    .tick (tick)
  );

  spi_rm_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .is_wr   (cmd_wr),
    .len_m1  (reg_wdata[C_LEN_LSB +: LEN_W]),
    .tx_word ({txhi_q, txlo_q}),
    .tick    (tick),
    .miso    (spi_miso),
    .busy    (busy),
    .phase   (phase),
    .mosi    (mosi_w),
    .rx_word (rx_word),
    .done_wr (done_wr),
    .done_rd (done_rd)
  );

  spi_rm_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .pulse_mode (setup2_q[S2_PULSE]),
    .act_high   (setup2_q[S2_POL]),
    .en_wr      (setup1_q[S1_IE_WR]),
    .en_rd      (setup1_q[S1_IE_RD]),
    .flag_wr    (flag_wr_q),
    .flag_rd    (flag_rd_q),
    .done_wr    (done_wr),
    .done_rd    (done_rd),
    .irq        (irq_w)
  );

  assign spi_sclk  = !setup2_q[S2_RISE] ^ phase;
  assign spi_mosi  = mosi_w;
  assign spi_cs_n  = cs_n_q;
  assign irq       = irq_w;
  assign reg_rdata = rdata_q;

  assert_start_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(setup1_q[S1_RUN]));
  assert_wrflag_from_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_wr_q) |-> $past(done_wr));
  assert_rdflag_from_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_rd_q) |-> $past(done_rd));
  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));
endmodule

// File: tb/test_spi_regmaster.sv
`timescale 1ns/1ps
module test_spi_regmaster;
  import spi_rm_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        spi_sclk, spi_mosi, irq;
  logic        spi_miso = 1'b0;
  logic [1:0]  spi_cs_n;

  always #2.5 clk = ~clk;

  spi_regmaster i_spi_regmaster (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  typedef struct { int nbits; logic [31:0] val; string req; } sb_item_t;
  sb_item_t sb_q[$];

  // bench-side state owned by the monitor/slave process
  bit          cfg_rise = 0;
  logic [31:0] slave_new = '0;
  int          slave_seq = 0;
  int          ncap = 0, act_gap = 0, irq_hi = 0, irq_lo = 0;

  // monitor + MISO slave: captures MOSI at each sampling edge, pops scoreboard
  initial begin
    logic        prev, cur, idle;
    logic [31:0] cap, slave_tx, msk;
    int          cyc, last_act, seen_seq;
    prev = 1'b1; cap = '0; slave_tx = '0; cyc = 0; last_act = 0; seen_seq = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (irq === 1'b1) irq_hi++; else irq_lo++;
      if (seen_seq != slave_seq) begin slave_tx = slave_new; seen_seq = slave_seq; end
      cur  = spi_sclk;
      idle = cfg_rise ? 1'b0 : 1'b1;
      if (!rst) begin
        if (prev == idle && cur != idle) begin
          cap = {cap[30:0], spi_mosi};
          ncap++;
          act_gap = cyc - last_act;
          last_act = cyc;
          if (sb_q.size() > 0 && ncap == sb_q[0].nbits) begin
            msk = (ncap == 32) ? 32'hFFFF_FFFF : ((32'd1 << ncap) - 1);
            check(sb_q[0].req, "MOSI word", cap & msk, sb_q[0].val);
            void'(sb_q.pop_front());
            ncap = 0;
          end
        end
        if (prev != idle && cur == idle) slave_tx = slave_tx << 1;
      end
      spi_miso = slave_tx[31];
      prev = cur;
    end
  end

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_flag(int b, string req);
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(IDX_STATUS, s);
      if (s[b]) return;
    end
    check(req, "done flag timeout", 32'd0, 32'd1);
  endtask

  // push the expected MOSI word, load the slave, issue the command
  task automatic start_xfer(bit is_wr, int n, logic [31:0] word, string req);
    sb_item_t it;
    it.nbits = n; it.req = req;
    if (is_wr) begin
      it.val = word >> (32 - n);
      wr_reg(IDX_TXLO, word[15:0]);
      wr_reg(IDX_TXHI, word[31:16]);
    end else begin
      it.val = '0;
      slave_new = word << (32 - n);
      slave_seq++;
      @(negedge clk);
    end
    sb_q.push_back(it);
    wr_reg(IDX_CTRL, 16'(((n - 1) << C_LEN_LSB) | (is_wr ? 2 : 1)));
  endtask

  task automatic run_xfer(bit is_wr, int n, logic [31:0] word, string req);
    start_xfer(is_wr, n, word, req);
    wait_flag(is_wr ? ST_WR : ST_RD, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", "cs_n", 32'(spi_cs_n), 32'h3);
    check("R1", "sclk idle", 32'(spi_sclk), 32'h1);
    check("R1", "irq", 32'(irq), 32'h1);
    rd_reg(IDX_STATUS, d); check("R1", "status", 32'(d), 32'h0);
    rd_reg(IDX_SETUP1, d); check("R1", "setup1", 32'(d), 32'h0);

    wr_reg(IDX_SETUP1, 16'h0001);

    // R2 writes of several lengths
    run_xfer(1, 16, 32'hA5C3_0000, "R2");
    run_xfer(1, 8,  32'h5A00_0000, "R2");
    run_xfer(1, 32, 32'h1234_ABCD, "R2");

    // R3 read 16
    run_xfer(0, 16, 32'h0000_3C96, "R3");
    rd_reg(IDX_RXLO, d); check("R3", "rx lo 16", 32'(d), 32'h3C96);
    rd_reg(IDX_RXHI, d); check("R3", "rx hi 16", 32'(d), 32'h0);

    // R4 flag behaviour
    rd_reg(IDX_STATUS, d); check("R4", "both flags", 32'(d), 32'h3);
    start_xfer(1, 16, 32'h0F0F_0000, "R4");
    rd_reg(IDX_STATUS, d); check("R4", "wr flag cleared, busy", 32'(d), 32'h5);
    wait_flag(ST_WR, "R4");
    wr_reg(IDX_STATUS, 16'h0002);
    rd_reg(IDX_STATUS, d); check("R4", "status write keeps ones", 32'(d), 32'h2);

    // R3 read 32 and read 4
    run_xfer(0, 32, 32'hDEAD_BEEF, "R3");
    rd_reg(IDX_RXLO, d); check("R3", "rx lo 32", 32'(d), 32'hBEEF);
    rd_reg(IDX_RXHI, d); check("R3", "rx hi 32", 32'(d), 32'hDEAD);
    run_xfer(0, 4, 32'h0000_000B, "R3");
    rd_reg(IDX_RXLO, d); check("R3", "rx lo 4", 32'(d), 32'h000B);

    // R6 second command while busy is dropped
    wr_reg(IDX_STATUS, 16'h0000);
    start_xfer(1, 16, 32'hF00F_0000, "R6");
    wr_reg(IDX_CTRL, 16'h001D);
    wait_flag(ST_WR, "R6");
    repeat (60) @(negedge clk);
    rd_reg(IDX_STATUS, d); check("R6", "no read done", 32'(d), 32'h2);
    check("R6", "no extra bits", 32'(ncap), 32'h0);

    // R5 disabled: command ignored
    wr_reg(IDX_SETUP1, 16'h0000);
    wr_reg(IDX_STATUS, 16'h0000);
    wr_reg(IDX_CTRL, 16'h003E);
    repeat (80) @(negedge clk);
    rd_reg(IDX_STATUS, d); check("R5", "status idle", 32'(d), 32'h0);
    check("R5", "no sclk edges", 32'(ncap), 32'h0);

    // R7 divisor 2 -> 8 cycles per bit
    wr_reg(IDX_SETUP1, 16'h0005);
    run_xfer(1, 4, 32'h9000_0000, "R7");
    check("R7", "bit period div2", 32'(act_gap), 32'd8);
    wr_reg(IDX_SETUP1, 16'h0001);
    run_xfer(1, 4, 32'h6000_0000, "R7");
    check("R7", "bit period div0", 32'(act_gap), 32'd2);

    // R8 rising-edge mode
    cfg_rise = 1;
    wr_reg(IDX_SETUP2, 16'h0001);
    repeat (2) @(negedge clk);
    check("R8", "sclk idle low", 32'(spi_sclk), 32'h0);
    run_xfer(1, 16, 32'h6E21_0000, "R8");
    run_xfer(0, 8, 32'h0000_00C4, "R8");
    rd_reg(IDX_RXLO, d); check("R8", "rx rising", 32'(d), 32'h00C4);

    // R9 chip selects
    wr_reg(IDX_CTRL, 16'h05FC);
    @(negedge clk); check("R9", "cs1 low", 32'(spi_cs_n), 32'h1);
    rd_reg(IDX_STATUS, d); check("R9", "no busy", 32'(d[ST_BUSY]), 32'h0);
    wr_reg(IDX_CTRL, 16'h057C);
    @(negedge clk); check("R9", "cs0 low", 32'(spi_cs_n), 32'h2);
    wr_reg(IDX_CTRL, 16'h05FD);
    @(negedge clk); check("R9", "released", 32'(spi_cs_n), 32'h3);
    check("R9", "no bits", 32'(ncap), 32'h0);

    // R10 level mode, active high, write irq only
    wr_reg(IDX_STATUS, 16'h0000);
    wr_reg(IDX_SETUP1, 16'h0011);
    wr_reg(IDX_SETUP2, 16'h0021);
    @(negedge clk); check("R10", "level idle", 32'(irq), 32'h0);
    run_xfer(1, 16, 32'h1111_0000, "R10");
    @(negedge clk); check("R10", "level asserted", 32'(irq), 32'h1);
    repeat (20) @(negedge clk); check("R10", "level held", 32'(irq), 32'h1);
    wr_reg(IDX_STATUS, 16'h0000);
    @(negedge clk); check("R10", "level cleared", 32'(irq), 32'h0);
    run_xfer(0, 8, 32'h0000_005A, "R10");
    repeat (3) @(negedge clk); check("R10", "read irq disabled", 32'(irq), 32'h0);

    // R10 pulse mode, active high then active low
    wr_reg(IDX_STATUS, 16'h0000);
    wr_reg(IDX_SETUP1, 16'h0021);
    wr_reg(IDX_SETUP2, 16'h0421);
    repeat (2) @(negedge clk);
    base = irq_hi;
    run_xfer(0, 8, 32'h0000_0033, "R10");
    repeat (10) @(negedge clk);
    check("R10", "pulse high count", 32'(irq_hi - base), 32'd1);
    wr_reg(IDX_SETUP2, 16'h0401);
    repeat (2) @(negedge clk);
    check("R10", "active-low idle", 32'(irq), 32'h1);
    base = irq_lo;
    run_xfer(0, 8, 32'h0000_0044, "R10");
    repeat (10) @(negedge clk);
    check("R10", "pulse low count", 32'(irq_lo - base), 32'd1);

    check("R2", "scoreboard drained", 32'(sb_q.size()), 32'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule